// File: doc/BRIEF.md
# Set/Clear Status Flag Register

This block holds the mode and error flags of a serial-port engine. Software never writes the flags directly. It writes a 16-bit command word, where each flag has one bit that sets it and another that clears it. Command bits written as zero leave their flags alone. This allows one flag to be changed without first reading the register back.

There are eight flags:
- run/configuration enable
- master select
- six error flags: transmit, receive, abort, mode, transmit underflow and receive underflow

The engine reports error events on a 5-bit input. Each event is captured into its error flag only when its capture enable is set. A read-only status word shows the flags together with the engine's busy line.

A 4-bit interrupt enable register gates four request outputs:
- receive
- transmit
- error
- frame end

The error request is driven by the error flags themselves.

Top module: `set_clear_status_reg`

## Requirements
- R1: After reset, every flag is zero: configuration mode, slave, no errors. The interrupt enable register is zero, so all four request outputs are low.
- R2: Status word bit positions: enable at 0, master select at 1, mode error at 7, transmit error at 8, receive error at 9, abort error at 10, transmit underflow at 11, receive underflow at 12. Bit 13 follows `busyIn`, and bits 14 and 15 read zero. Enable = 0 means configuration mode and enable = 1 means run mode.
- R3: A command write takes effect at the next clock edge. The command bits are: clear/set enable at 0/1, clear/set master at 2/3, clear/set receive underflow at 4/5, clear/set mode error at 6/7. Clear transmit, receive, abort and transmit underflow errors are at bits 8, 9, 10 and 11. The matching set bits are at 12, 13, 14 and 15. Command bits written as zero leave their flags unchanged.
- R4: If a command writes both the set bit and the clear bit of one flag, that flag keeps its value.
- R5: The command 0x0F50 clears all six error flags and leaves enable and master select unchanged.
- R6: `hwErr` and `errCapEn` use the same bit order: transmit overflow at 0, receive overflow at 1, abort at 2, transmit underflow at 3, receive underflow at 4. An event whose capture enable is 1 sets the matching error flag at the next edge.
- R7: An event whose capture enable is 0 does not change its flag.
- R8: A captured event wins over a command clear of the same flag in the same cycle, so the flag ends up set.
- R9: A write on `irqEnWr` loads the interrupt enable register at the next edge. Enable bits are receive at 0, transmit at 1, error at 2, frame end at 3. Each request output is its request input ANDed with its enable bit, and `irqOut` uses the same bit order.
- R10: The error request, `irqOut[2]`, is high exactly while at least one error flag is set and the error enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWr | input | 1 | Command word write strobe |
| cmdData | input | 16 | Command word (set/clear bits) |
| errCapEn | input | 5 | Per-error capture enables |
| hwErr | input | 5 | Error event pulses from the engine |
| busyIn | input | 1 | Engine busy, shown in the status word |
| irqEnWr | input | 1 | Interrupt enable register write strobe |
| irqEnData | input | 4 | Interrupt enable write data |
| rxReq | input | 1 | Receive request from the engine |
| txReq | input | 1 | Transmit request from the engine |
| frameReq | input | 1 | Frame-end request from the engine |
| statusWord | output | 16 | Read-only status word |
| irqOut | output | 4 | Gated requests: receive, transmit, error, frame end |

## Verification
The assertions check, on every cycle:
- an all-zero command leaves the flags unchanged;
- a flag written with both set and clear holds its value;
- the all-errors clear mask leaves only enable and master select;
- captured events set their flags, and they win over a clear in the same cycle;
- events that are not enabled leave their flags alone;
- the error request never rises while no error flag is set.

Only the bench scenarios can show:
- the exact bit positions of each command bit and status bit;
- the sweep over every pairing of capture enable and event;
- the full gating of the four request outputs by every enable value;
- busy appearing at bit 13.

// File: rtl/scsr_pkg.sv
package scsr_pkg;
  localparam int CMD_W  = 16;
  localparam int STAT_W = 16;
  localparam int NFLAG  = 8;
  localparam int NERR   = 5;
  localparam int NIRQ   = 4;
  localparam int ERR_LO = 2;
  localparam int BUSY_POS = 13;

  // Flag index order: enable, master, txErr, rxErr, abort, txUnd, rxUnd, modeErr
  localparam int SET_POS  [NFLAG] = '{1, 3, 12, 13, 14, 15, 5, 7};
  localparam int CLR_POS  [NFLAG] = '{0, 2, 8, 9, 10, 11, 4, 6};
  localparam int STAT_POS [NFLAG] = '{0, 1, 8, 9, 10, 11, 12, 7};

  typedef struct packed {
    logic [NFLAG-1:0] setF;
    logic [NFLAG-1:0] clrF;
    logic             irqLoad;
  } strobeT;
endpackage

// File: rtl/scsr_ctrl.sv
module scsr_ctrl
  import scsr_pkg::*;
(
  input  logic             cmdWr,
  input  logic [CMD_W-1:0] cmdData,
  input  logic [NERR-1:0]  hwErr,
  input  logic [NERR-1:0]  errCapEn,
  input  logic             irqEnWr,
  output strobeT           strobes
);
  logic [NFLAG-1:0] cmdSet, cmdClr, hwSet;

  for (genvar i = 0; i < NFLAG; i++) begin : g_cmd
    assign cmdSet[i] = cmdWr & cmdData[SET_POS[i]];
    assign cmdClr[i] = cmdWr & cmdData[CLR_POS[i]];
    if (i >= ERR_LO && i < ERR_LO + NERR) begin : g_hw
      assign hwSet[i] = hwErr[i-ERR_LO] & errCapEn[i-ERR_LO];
    end else begin : g_nohw
      assign hwSet[i] = 1'b0;
    end
  end

  always_comb begin
    strobes.setF    = hwSet | (cmdSet & ~cmdClr);
    strobes.clrF    = cmdClr & ~cmdSet & ~hwSet;
    strobes.irqLoad = irqEnWr;
  end
endmodule

// File: rtl/scsr_datapath.sv
module scsr_datapath
  import scsr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobes,
  input  logic [NIRQ-1:0]   irqEnData,
  input  logic              busyIn,
  input  logic              rxReq,
  input  logic              txReq,
  input  logic              frameReq,
  output logic [STAT_W-1:0] statusWord,
  output logic [NIRQ-1:0]   irqOut
);
  logic [NFLAG-1:0] flags;
  logic [NIRQ-1:0]  irqEnQ;
  logic             errAny;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)                flags[i] <= 1'b0;
      else if (strobes.setF[i]) flags[i] <= 1'b1;
      else if (strobes.clrF[i]) flags[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                irqEnQ <= '0;
    else if (strobes.irqLoad) irqEnQ <= irqEnData;
  end

  assign errAny = |flags[NFLAG-1:ERR_LO];

  always_comb begin
    statusWord = '0;
    for (int i = 0; i < NFLAG; i++) statusWord[STAT_POS[i]] = flags[i];
    statusWord[BUSY_POS] = busyIn;
  end

  assign irqOut = irqEnQ & {frameReq, errAny, txReq, rxReq};
endmodule

// File: rtl/set_clear_status_reg.sv
module set_clear_status_reg
  import scsr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWr,
  input  logic [CMD_W-1:0]  cmdData,
  input  logic [NERR-1:0]   errCapEn,
  input  logic [NERR-1:0]   hwErr,
  input  logic              busyIn,
  input  logic              irqEnWr,
  input  logic [NIRQ-1:0]   irqEnData,
  input  logic              rxReq,
  input  logic              txReq,
  input  logic              frameReq,
  output logic [STAT_W-1:0] statusWord,
  output logic [NIRQ-1:0]   irqOut
);
  strobeT strobes;

  scsr_ctrl u_ctrl (
    .cmdWr    (cmdWr),
    .cmdData  (cmdData),
    .hwErr    (hwErr),
    .errCapEn (errCapEn),
    .irqEnWr  (irqEnWr),
    .strobes  (strobes)
  );

  scsr_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .irqEnData  (irqEnData),
    .busyIn     (busyIn),
    .rxReq      (rxReq),
    .txReq      (txReq),
    .frameReq   (frameReq),
    .statusWord (statusWord),
    .irqOut     (irqOut)
  );
endmodule

// File: rtl/scsr_checker.sv
module scsr_checker
  import scsr_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             cmdWr,
  input logic [CMD_W-1:0] cmdData,
  input logic [NERR-1:0]  errCapEn,
  input logic [NERR-1:0]  hwErr,
  input logic [12:0]      statusLow,
  input logic             errIrq
);
  // R3: an all-zero command with no events leaves the flags unchanged
  a_r3_zero_cmd_holds: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && cmdData == '0 && hwErr == '0) |=> (statusLow == $past(statusLow)));

  // R4: set and clear of enable written together hold the enable flag
  a_r4_conflict_holds: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && cmdData[1:0] == 2'b11) |=> (statusLow[0] == $past(statusLow[0])));

  // R5: the clear-all-errors mask leaves only enable and master select
  a_r5_clear_all_errors: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && cmdData == 16'h0F50 && hwErr == '0)
      |=> (statusLow == {11'd0, $past(statusLow[1:0])}));

  for (genvar k = 0; k < NERR; k++) begin : g_err
    // R6 and R8: a captured event sets its flag even against a clear
    a_r6_capture_sets: assert property (@(posedge clk) disable iff (!rstN)
      (hwErr[k] && errCapEn[k]) |=> statusLow[8+k]);
    // R7: an event that is not enabled, with no command, changes nothing
    a_r7_masked_ignored: assert property (@(posedge clk) disable iff (!rstN)
      (hwErr[k] && !errCapEn[k] && !cmdWr) |=> (statusLow[8+k] == $past(statusLow[8+k])));
  end

  // R10: the error request requires at least one error flag
  a_r10_err_irq_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    errIrq |-> (|statusLow[12:7]));
endmodule

bind set_clear_status_reg scsr_checker u_scsr_checker (
  .clk       (clk),
  .rstN      (rstN),
  .cmdWr     (cmdWr),
  .cmdData   (cmdData),
  .errCapEn  (errCapEn),
  .hwErr     (hwErr),
  .statusLow (statusWord[12:0]),
  .errIrq    (irqOut[2])
);

// File: tb/test_set_clear_status_reg.sv
module test_set_clear_status_reg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWr = 1'b0;
  logic [15:0] cmdData = '0;
  logic [4:0]  errCapEn = '0;
  logic [4:0]  hwErr = '0;
  logic        busyIn = 1'b0;
  logic        irqEnWr = 1'b0;
  logic [3:0]  irqEnData = '0;
  logic        rxReq = 1'b0, txReq = 1'b0, frameReq = 1'b0;
  logic [15:0] statusWord;
  logic [3:0]  irqOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [15:0] expS = '0;

  // Bit positions taken from R2/R3, flag order en, ms, tx, rx, ab, txu, rxu, mode
  int setB [8] = '{1, 3, 12, 13, 14, 15, 5, 7};
  int clrB [8] = '{0, 2, 8, 9, 10, 11, 4, 6};
  int stB  [8] = '{0, 1, 8, 9, 10, 11, 12, 7};

  always #10 clk = ~clk;

  set_clear_status_reg i_set_clear_status_reg (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdData(cmdData),
    .errCapEn(errCapEn), .hwErr(hwErr), .busyIn(busyIn),
    .irqEnWr(irqEnWr), .irqEnData(irqEnData), .rxReq(rxReq),
    .txReq(txReq), .frameReq(frameReq), .statusWord(statusWord),
    .irqOut(irqOut)
  );

  function automatic logic [15:0] nextS(logic [15:0] s, logic w, logic [15:0] c,
                                        logic [4:0] h, logic [4:0] en);
    logic [15:0] r = s;
    for (int i = 0; i < 8; i++) begin
      logic sb = w & c[setB[i]];
      logic cb = w & c[clrB[i]];
      logic hb = (i >= 2 && i <= 6) ? (h[i-2] & en[i-2]) : 1'b0;
      if (hb || (sb && !cb)) r[stB[i]] = 1'b1;
      else if (cb && !sb)    r[stB[i]] = 1'b0;
    end
    return r;
  endfunction

  task automatic chk(logic ok, string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic w, logic [15:0] c, logic [4:0] h, logic [4:0] en);
    cmdWr = w; cmdData = c; hwErr = h; errCapEn = en;
    @(posedge clk);
    expS = nextS(expS, w, c, h, en);
    @(negedge clk);
    cmdWr = 0; cmdData = '0; hwErr = '0;
  endtask

  task automatic chkStat(string tag);
    logic [15:0] e = expS;
    e[13] = busyIn;
    chk(statusWord == e, tag, statusWord, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(statusWord == 16'h0, "R1 status", statusWord, 16'h0);
    rxReq = 1; txReq = 1; frameReq = 1;
    #1 chk({12'd0, irqOut} == 16'h0, "R1 irq", {12'd0, irqOut}, 16'h0);
    rxReq = 0; txReq = 0; frameReq = 0;

    // R3 single command bits from all-set and all-clear states (R2 positions)
    for (int b = 0; b < 16; b++) begin
      step(1, 16'hF0AA, '0, '0);
      chkStat("R3 all-set");
      step(1, 16'(1 << b), '0, '0);
      chkStat("R3 single bit from ones");
      step(1, 16'h0F55, '0, '0);
      chkStat("R3 all-clear");
      step(1, 16'(1 << b), '0, '0);
      chkStat("R3 single bit from zeros");
    end
    step(1, 16'h0000, '0, '0);
    chkStat("R3 zero command");

    // R4 set and clear together per flag
    for (int i = 0; i < 8; i++) begin
      step(1, 16'hF0AA, '0, '0);
      step(1, 16'((1 << setB[i]) | (1 << clrB[i])), '0, '0);
      chkStat("R4 both from ones");
      step(1, 16'h0F55, '0, '0);
      step(1, 16'((1 << setB[i]) | (1 << clrB[i])), '0, '0);
      chkStat("R4 both from zeros");
    end

    // R5 clear-all-errors mask
    step(1, 16'hF0AA, '0, '0);
    step(1, 16'h0F50, '0, '0);
    chk(statusWord[12:0] == 13'h0003, "R5 from ones", statusWord, 16'h0003);
    step(1, 16'hF0A5, '0, '0);
    step(1, 16'h0F50, '0, '0);
    chk(statusWord[12:0] == 13'h0000, "R5 en/ms clear", statusWord, 16'h0000);

    // R6/R7 full sweep of capture enables and events
    for (int en = 0; en < 32; en++) begin
      for (int ev = 0; ev < 32; ev++) begin
        step(1, 16'h0F50, '0, '0);
        step(0, '0, 5'(ev), 5'(en));
        chk(statusWord[12:8] == 5'(ev & en), "R6 R7 capture", {11'd0, statusWord[12:8]},
            16'(ev & en));
      end
    end

    // R8 captured event beats a command clear in the same cycle
    step(1, 16'h0F50, '0, '0);
    step(1, 16'h0F50, 5'h1F, 5'h1F);
    chkStat("R8 event wins");
    step(1, 16'h0F50, 5'h05, 5'h01);
    chkStat("R8 partial");

    // R2 busy at bit 13
    busyIn = 1; #1 chkStat("R2 busy high");
    busyIn = 0; #1 chkStat("R2 busy low");

    // R9/R10 interrupt gating sweep
    for (int e = 0; e < 16; e++) begin
      for (int errSt = 0; errSt < 2; errSt++) begin
        step(1, errSt ? 16'h0080 : 16'h0F50, '0, '0);
        irqEnWr = 1; irqEnData = 4'(e);
        @(posedge clk); @(negedge clk);
        irqEnWr = 0;
        for (int rq = 0; rq < 8; rq++) begin
          logic [3:0] expI;
          rxReq = rq[0]; txReq = rq[1]; frameReq = rq[2];
          expI = 4'(e) & {rq[2], errSt[0], rq[1], rq[0]};
          #1 chk(irqOut == expI, "R9 R10 irq", {12'd0, irqOut}, {12'd0, expI});
        end
        rxReq = 0; txReq = 0; frameReq = 0;
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule